// File: doc/BRIEF.md
# Pulse-Width Symbol Line Decoder

This block listens to one open-drain serial wire where every bit period opens with a rising edge and a high phase. The length of that high phase carries one of three symbols: a short high is a zero, a half-period high is a one, and a long high is the separator. The decoder synchronises the wire into the local clock domain, measures each high run and each low run in local clock cycles, and compares them against thresholds set in sixteenths of the nominal bit time. Each time a period's high phase ends, it issues a one-cycle strobe with a 2-bit symbol code.

Besides symbols, it watches three line states. A wire that stays high past the point where any symbol could still end is flagged as passive idle. A wire held low for more than two nominal bit times is flagged as a bus reset or fault. While idle, a low pulse of at least one sixteenth of a bit time raises a single-cycle wake-up strobe, and a shorter dip is dropped as a glitch. The symbol output has no back-pressure. The wire cannot be paused, so a consumer must take every strobe in the cycle it appears. The nominal bit time `BIT_CLKS` is a parameter in local clock cycles and should be a multiple of 16.

Top module: `pwmsl_decoder`

## Requirements
- R1: A period whose high run is shorter than 6/16 of `BIT_CLKS` clock cycles yields code 2'b00 (zero symbol).
- R2: A period whose high run is at least 6/16 and below 10/16 of `BIT_CLKS` yields code 2'b01 (one symbol).
- R3: A period whose high run is at least 10/16 and at most 14/16 of `BIT_CLKS` yields code 2'b10 (separator symbol).
- R4: Exactly one `sym_valid_o` strobe, one cycle wide, is issued for each period begun by a rising edge outside idle and reset, at the end of its high run. The code 2'b11 never appears.
- R5: A high run longer than 14/16 of `BIT_CLKS` sets `idle_o` and yields no symbol. `idle_o` clears at the next rising edge that ends a low pulse of at least 1/16 bit time.
- R6: A low run longer than 2*`BIT_CLKS` cycles sets `bus_reset_o` and clears `idle_o`. A low run of exactly 2*`BIT_CLKS` does not set it. `bus_reset_o` clears at the next rising edge.
- R7: While `idle_o` is set, a low run that reaches `BIT_CLKS`/16 cycles gives one single-cycle `wake_o` strobe.
- R8: While `idle_o` is set, a low pulse shorter than `BIT_CLKS`/16 cycles gives no wake strobe and no symbol, and `idle_o` stays set.
- R9: During and just after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw bus wire, asynchronous to clk |
| sym_valid_o | output | 1 | One-cycle strobe, a symbol was decoded |
| sym_code_o | output | 2 | Symbol code: 00 zero, 01 one, 10 separator |
| idle_o | output | 1 | Wire is passive high |
| bus_reset_o | output | 1 | Wire held low past two bit times |
| wake_o | output | 1 | One-cycle wake-up strobe seen during idle |

## Verification
The bench builds the decoder with `BIT_CLKS` = 32, so one sixteenth is two clocks. A one-clock dip is therefore a sub-threshold glitch, while a two-clock dip is the shortest legal wake pulse. At this bit time the reset threshold of 64 low cycles is reached quickly, so the bench can place low runs of exactly 64 and of 70 cycles side by side. Each symbol boundary (11/12, 19/20 and 28/29 high cycles) falls on a whole clock, so directed periods can sit exactly on both sides of every threshold. Random jittered periods are mixed in.

// File: rtl/pwmsl_pkg.sv
package pwmsl_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_SEP  = 2'b10
  } sym_e;
endpackage

// File: rtl/pwmsl_sync.sv
module pwmsl_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RESET_VAL;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pwmsl_runlen.sv
module pwmsl_runlen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_i,
  output logic          rise_o,
  output logic          fall_o,
  output logic [CW-1:0] hi_run_o,
  output logic [CW-1:0] lo_run_o
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic          prev_q;
  logic [CW-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      prev_q <= s_i;
      if (s_i) begin
        lo_q <= '0;
        if (hi_q != SAT) hi_q <= hi_q + 1'b1;
      end else begin
        hi_q <= '0;
        if (lo_q != SAT) lo_q <= lo_q + 1'b1;
      end
    end
  end

  assign rise_o   = s_i & ~prev_q;
  assign fall_o   = ~s_i & prev_q;
  assign hi_run_o = hi_q;
  assign lo_run_o = lo_q;

  assert_runs_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q != '0 && lo_q != '0));
endmodule

// File: rtl/pwmsl_classify.sv
module pwmsl_classify
  import pwmsl_pkg::*;
#(
  parameter int CW    = 8,
  parameter int TH_LO = 6,
  parameter int TH_HI = 10
) (
  input  logic [CW-1:0] hi_run_i,
  output sym_e          code_o
);
  always_comb begin
    if (hi_run_i < CW'(TH_LO))      code_o = SYM_ZERO;
    else if (hi_run_i < CW'(TH_HI)) code_o = SYM_ONE;
    else                            code_o = SYM_SEP;
  end
endmodule

// File: rtl/pwmsl_decoder.sv
module pwmsl_decoder
  import pwmsl_pkg::*;
#(
  parameter int BIT_CLKS    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       sym_valid_o,
  output logic [1:0] sym_code_o,
  output logic       idle_o,
  output logic       bus_reset_o,
  output logic       wake_o
);
  localparam int UNIT     = BIT_CLKS / 16;
  localparam int TH_LO    = 6 * UNIT;
  localparam int TH_HI    = 10 * UNIT;
  localparam int IDLE_TH  = 14 * UNIT;
  localparam int WAKE_MIN = UNIT;
  localparam int RESET_TH = 2 * BIT_CLKS;
  localparam int CW       = $clog2(RESET_TH + 2);

  logic          line_s;
  logic          rise, fall;
  logic [CW-1:0] hi_run, lo_run;
  sym_e          code_c;

  logic          idle_q, rst_q, active_q, wake_q, vld_q;
  sym_e          code_q;

  pwmsl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  pwmsl_runlen #(.CW(CW)) u_runs (
    .clk(clk), .rst_n(rst_n), .s_i(line_s),
    .rise_o(rise), .fall_o(fall), .hi_run_o(hi_run), .lo_run_o(lo_run)
  );

  pwmsl_classify #(.CW(CW), .TH_LO(TH_LO), .TH_HI(TH_HI)) u_cls (
    .hi_run_i(hi_run), .code_o(code_c)
  );

  logic glitch_c, idle_hit_c, rst_hit_c, wake_hit_c;
  assign glitch_c   = idle_q && (lo_run < CW'(WAKE_MIN));
  assign idle_hit_c = line_s && (hi_run >= CW'(IDLE_TH));
  assign rst_hit_c  = !line_s && (lo_run == CW'(RESET_TH));
  assign wake_hit_c = !line_s && idle_q && (lo_run == CW'(WAKE_MIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q   <= 1'b0;
      rst_q    <= 1'b0;
      active_q <= 1'b0;
      wake_q   <= 1'b0;
      vld_q    <= 1'b0;
      code_q   <= SYM_ZERO;
    end else begin
      vld_q  <= 1'b0;
      wake_q <= wake_hit_c;
      if (rise && !glitch_c) begin
        idle_q   <= 1'b0;
        rst_q    <= 1'b0;
        active_q <= 1'b1;
      end
      if (idle_hit_c) begin
        idle_q   <= 1'b1;
        active_q <= 1'b0;
      end
      if (fall && active_q) begin
        vld_q  <= 1'b1;
        code_q <= code_c;
      end
      if (rst_hit_c) begin
        rst_q    <= 1'b1;
        idle_q   <= 1'b0;
        active_q <= 1'b0;
      end
    end
  end

  assign sym_valid_o = vld_q;
  assign sym_code_o  = code_q;
  assign idle_o      = idle_q;
  assign bus_reset_o = rst_q;
  assign wake_o      = wake_q;

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |=> !sym_valid_o);
  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> (sym_code_o != 2'b11));
  assert_no_symbol_in_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> (!idle_o && !bus_reset_o));
  assert_idle_on_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(line_s));
  assert_reset_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_reset_o) |-> $past(!line_s));
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_o && bus_reset_o));
  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  assert_wake_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(idle_q));
endmodule

// File: tb/pwmsl_decoder_test.sv
`timescale 1ns/1ps
module pwmsl_decoder_test;
  localparam int B = 32;
  localparam int U = B / 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic       sym_valid_o, idle_o, bus_reset_o, wake_o;
  logic [1:0] sym_code_o;

  int checks = 0, failures = 0;
  int wakes = 0, rst_rises = 0, exp_wakes = 0;
  logic prev_rst = 1'b0;
  logic [1:0] got_q[$];
  logic [1:0] exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwmsl_decoder #(.BIT_CLKS(B)) uut (
    .clk(clk), .rst_n(rst_n), .line_i(line),
    .sym_valid_o(sym_valid_o), .sym_code_o(sym_code_o),
    .idle_o(idle_o), .bus_reset_o(bus_reset_o), .wake_o(wake_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_valid_o) got_q.push_back(sym_code_o);
      if (wake_o) wakes++;
      if (bus_reset_o && !prev_rst) rst_rises++;
    end
    prev_rst <= bus_reset_o;
  end

  function automatic logic [1:0] exp_code(input int hi);
    if (hi < 6*U) return 2'b00;
    if (hi < 10*U) return 2'b01;
    return 2'b10;
  endfunction

  function automatic string tag_of(input logic [1:0] c);
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic period(input int hi, input int tot);
    drive(1'b1, hi);
    drive(1'b0, tot - hi);
    exp_q.push_back(exp_code(hi));
  endtask

  task automatic compare_syms();
    repeat (6) @(negedge clk);
    chk(got_q.size() == exp_q.size(), "R4 strobe count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], tag_of(exp_q[i]), got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi_list[9];
    hi_list = '{8, 16, 24, 11, 12, 19, 20, 28, 6};
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: all outputs quiet out of reset
    chk({sym_valid_o, idle_o, bus_reset_o, wake_o} == 4'b0, "R9 reset state",
        {sym_valid_o, idle_o, bus_reset_o, wake_o}, 0);

    // R5: passive high becomes idle
    drive(1'b1, 40);
    chk(idle_o == 1'b1, "R5 idle set", idle_o, 1);
    chk(got_q.size() == 0, "R5 no symbol in idle", got_q.size(), 0);

    // R7: wake pulse from idle
    drive(1'b0, 10);
    exp_wakes++;
    chk(wakes == exp_wakes, "R7 wake", wakes, exp_wakes);

    // R1 R2 R3: directed periods including every threshold edge
    foreach (hi_list[i]) period(hi_list[i], B);
    drive(1'b1, 50);
    compare_syms();
    chk(idle_o == 1'b1, "R5 idle after long high", idle_o, 1);

    // R8: sub-threshold dip in idle
    drive(1'b0, 1);
    drive(1'b1, 20);
    chk(wakes == exp_wakes, "R8 glitch no wake", wakes, exp_wakes);
    chk(idle_o == 1'b1, "R8 idle kept", idle_o, 1);
    chk(got_q.size() == 0, "R8 no symbol", got_q.size(), 0);

    // R7: minimum wake width
    drive(1'b0, U);
    drive(1'b1, 40);
    exp_wakes++;
    chk(wakes == exp_wakes, "R7 minimum wake", wakes, exp_wakes);
    chk(idle_o == 1'b1 && got_q.size() == 0, "R5 idle again, no symbol",
        got_q.size(), 0);

    // R6: exactly two bit times low does not flag reset
    drive(1'b0, 2*B);
    exp_wakes++;
    drive(1'b1, 40);
    chk(rst_rises == 0, "R6 boundary", rst_rises, 0);

    // R6: longer low flags reset and drops idle
    drive(1'b0, 2*B + 6);
    exp_wakes++;
    chk(bus_reset_o == 1'b1, "R6 reset set", bus_reset_o, 1);
    chk(idle_o == 1'b0, "R6 idle cleared", idle_o, 0);
    drive(1'b1, 16);
    chk(bus_reset_o == 1'b0, "R6 reset cleared on rise", bus_reset_o, 0);
    drive(1'b0, 16);
    exp_q.push_back(2'b01);
    drive(1'b1, 40);
    compare_syms();
    chk(wakes == exp_wakes, "R7 wake count", wakes, exp_wakes);

    // Random jittered stream with occasional idle gaps
    drive(1'b0, 8);
    exp_wakes++;
    for (int n = 0; n < 300; n++) begin
      int cls, hi, tot;
      cls = $urandom % 3;
      tot = B - 2 + ($urandom % 5);
      if (cls == 0)      hi = 2 + ($urandom % (6*U - 2));
      else if (cls == 1) hi = 6*U + ($urandom % (4*U));
      else               hi = 10*U + ($urandom % (4*U + 1));
      period(hi, tot);
      if ($urandom % 20 == 0) begin
        drive(1'b1, 40);
        drive(1'b0, 8);
        exp_wakes++;
      end
    end
    drive(1'b1, 40);
    compare_syms();
    chk(wakes == exp_wakes, "R7 wake count random", wakes, exp_wakes);
    chk(idle_o == 1'b1, "R5 final idle", idle_o, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule